// File: doc/BRIEF.md
# Serial Register Write Receiver

This block turns a three-wire serial write link into parallel register writes for a register bank. The link has an active-low frame strobe, a serial clock and a serial data line. All three are brought into the system clock domain through synchronisers. Data bits are sampled on each serial clock rising edge while the frame strobe is low.

Every frame opens with an 8-bit register address. One or more 24-bit data words follow it. Address and data both arrive least significant bit first. Each complete word produces a single-cycle write pulse, carrying the address and the word. When the frame strobe stays low, the next word goes to the following address. The address wraps from 0xFF to 0x00, so one frame can load a run of consecutive registers anywhere in the space.

Releasing the frame strobe ends the frame. It discards any word that is not yet complete, and the next frame begins again with an address.

Top module: `serial_wr_rx`

## Requirements
- R1: After reset, `wrStrobe` is 0, and `wrAddr` and `wrData` are all zeros.
- R2: Bits are taken only on serial clock rising edges seen while the synchronised frame strobe is low. Serial clock edges while the strobe is high produce no write and do not disturb the next frame.
- R3: The first 8 bits of a frame form the write address. The first bit received becomes address bit 0, and the eighth becomes bit 7.
- R4: The 24 bits after the address form a data word. The first of them becomes `wrData` bit 0, and the last becomes bit 23. The word is presented on `wrData` together with its address on `wrAddr`.
- R5: Each completed word raises `wrStrobe` for exactly one system clock cycle.
- R6: While the frame strobe stays low, each further 24-bit word is written to the previous word's address plus one.
- R7: In a burst, the address after 0xFF is 0x00.
- R8: A data word with fewer than 24 bits when the frame strobe rises produces no write. Words completed earlier in the same frame are still written, and the next frame starts with a fresh address.
- R9: A frame that ends before all 8 address bits have arrived produces no write.
- R10: If a serial clock rising edge and the frame strobe release reach the synchronised domain in the same cycle, that edge is not sampled. A word whose 24th edge coincides with the release is therefore not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClkIn | input | 1 | Serial clock; bits are taken on its rising edge |
| serLoadN | input | 1 | Active-low frame strobe |
| serDataIn | input | 1 | Serial data, least significant bit first |
| wrStrobe | output | 1 | One-cycle write pulse per complete word |
| wrAddr | output | 8 | Register address of the current write |
| wrData | output | 24 | Data word of the current write |

## Verification
Two events can land in the same system cycle: the serial clock edge that would complete a word, and the release of the frame strobe that aborts it. The bench provokes this by driving the final rising edge and the strobe release in the same instant. Both pass through synchronisers of equal depth, so they are seen together. A pass requires that the earlier words of that burst are written and the coincident word is not. Random frames mix full words and truncated words. Every write pulse is compared against a queue of expected address/data pairs, and that queue must be empty at the end of each frame.

// File: rtl/serial_wr_rx_pkg.sv
package serial_wr_rx_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic takeBit;    // shift the current data bit in
    logic latchAddr;  // this bit completes the address
    logic emitWord;   // this bit completes a data word
    logic restart;    // frame strobe is inactive
  } rxCtl_t;
endpackage

// File: rtl/serial_wr_rx_sync.sv
module serial_wr_rx_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= RST_VAL;
          else       chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= RST_VAL;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_wr_rx_ctrl.sv
module serial_wr_rx_ctrl
  import serial_wr_rx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sckLvl,
  input  logic   loadNLvl,
  output rxCtl_t ctl
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic             sckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             addrPhase;
  logic             sckRise;
  logic             frameOn;

  assign sckRise = sckLvl & ~sckPrev;
  assign frameOn = ~loadNLvl;

  always_comb begin
    ctl = '0;
    ctl.restart = ~frameOn;
    if (frameOn && sckRise) begin
      ctl.takeBit = 1'b1;
      if (addrPhase && bitCnt == ADDR_LAST)  ctl.latchAddr = 1'b1;
      if (!addrPhase && bitCnt == DATA_LAST) ctl.emitWord  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev   <= 1'b0;
      bitCnt    <= '0;
      addrPhase <= 1'b1;
    end else begin
      sckPrev <= sckLvl;
      if (ctl.restart) begin
        bitCnt    <= '0;
        addrPhase <= 1'b1;
      end else if (ctl.takeBit) begin
        if (ctl.latchAddr || ctl.emitWord) begin
          bitCnt    <= '0;
          addrPhase <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameOn |=> (bitCnt == '0 && addrPhase));
  // R3
  addr_cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrPhase |-> (bitCnt < CNT_W'(ADDR_W)));
  // R4
  data_cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(DATA_W));
  // R9
  no_word_in_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchAddr |=> !addrPhase);
endmodule

// File: rtl/serial_wr_rx_dp.sv
module serial_wr_rx_dp
  import serial_wr_rx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataBit,
  input  rxCtl_t            ctl,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;
  logic [ADDR_W-1:0] addrReg;

  assign shiftNext = {dataBit, shiftReg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= 1'b0;
      if (ctl.takeBit) shiftReg <= shiftNext;
      if (ctl.latchAddr) addrReg <= shiftNext[DATA_W-1 -: ADDR_W];
      if (ctl.emitWord) begin
        wrStrobe <= 1'b1;
        wrAddr   <= addrReg;
        wrData   <= shiftNext;
        addrReg  <= addrReg + 1'b1;
      end
    end
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);
  // R6
  burst_addr_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (addrReg == ADDR_W'(wrAddr + 1'b1)));
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.emitWord |=> ($stable(wrAddr) && $stable(wrData)));
endmodule

// File: rtl/serial_wr_rx.sv
module serial_wr_rx
  import serial_wr_rx_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClkIn,
  input  logic        serLoadN,
  input  logic        serDataIn,
  output logic        wrStrobe,
  output logic [7:0]  wrAddr,
  output logic [23:0] wrData
);
  logic   sckSync;
  logic   loadNSync;
  logic   dataSync;
  rxCtl_t ctl;
  logic [ADDR_W-1:0] addrInt;
  logic [DATA_W-1:0] dataInt;

  serial_wr_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uSckSync (
    .clk(clk), .rstN(rstN), .din(serClkIn), .dout(sckSync));
  serial_wr_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uLoadSync (
    .clk(clk), .rstN(rstN), .din(serLoadN), .dout(loadNSync));
  serial_wr_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uDataSync (
    .clk(clk), .rstN(rstN), .din(serDataIn), .dout(dataSync));

  serial_wr_rx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckLvl(sckSync), .loadNLvl(loadNSync), .ctl(ctl));

  serial_wr_rx_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dataBit(dataSync), .ctl(ctl),
    .wrStrobe(wrStrobe), .wrAddr(addrInt), .wrData(dataInt));

  assign wrAddr = 8'(addrInt);
  assign wrData = 24'(dataInt);

  // R2
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !$past(loadNSync));
endmodule

// File: tb/tb_serial_wr_rx.sv
module tb_serial_wr_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClkIn = 1'b0;
  logic        serLoadN = 1'b1;
  logic        serDataIn = 1'b0;
  logic        wrStrobe;
  logic [7:0]  wrAddr;
  logic [23:0] wrData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  string curReq = "R4";
  bit prevStrobe = 1'b0;

  serial_wr_rx dut (.clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serLoadN(serLoadN),
    .serDataIn(serDataIn), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] burstAddr(logic [7:0] base, int idx);
    return 8'(base + idx);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write monitor
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (wrStrobe) begin
        check("R5", {31'd0, prevStrobe}, 32'd0);
        if (expQ.size() == 0) check({curReq, " unexpected write"}, {wrAddr, wrData}, 32'hDEAD_BEEF);
        else check(curReq, {wrAddr, wrData}, expQ.pop_front());
      end
      prevStrobe = wrStrobe;
    end
    if (cycles > 190000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    serDataIn = b; waitClk(HOLD);
    serClkIn = 1'b1; waitClk(HOLD);
    serClkIn = 1'b0; waitClk(HOLD);
  endtask

  task automatic sendBits(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) sendBit(v[i]);
  endtask

  task automatic frameStart();
    serLoadN = 1'b0; waitClk(HOLD);
  endtask

  task automatic frameEnd(string req);
    serLoadN = 1'b1; waitClk(8);
    check({req, " pending writes"}, expQ.size(), 0);
    expQ.delete();
  endtask

  // Burst of nWords full words, optionally a truncated tail of tailBits
  task automatic burst(string req, logic [7:0] base, int nWords, int tailBits);
    curReq = req;
    frameStart();
    sendBits({24'd0, base}, 8);
    for (int w = 0; w < nWords; w++) begin
      logic [23:0] d = 24'($urandom);
      expQ.push_back({burstAddr(base, w), d});
      sendBits({8'd0, d}, 24);
    end
    if (tailBits > 0) sendBits($urandom, tailBits);
    frameEnd(req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    waitClk(4);
    check("R1 reset", {7'd0, wrStrobe, wrAddr, wrData[15:0]}, 32'd0);
    check("R1 reset", {8'd0, wrData}, 32'd0);
    rstN = 1'b1;
    waitClk(4);

    // R3 R4: single directed word, LSB first
    curReq = "R3";
    frameStart();
    sendBits(32'h0000_00A5, 8);
    expQ.push_back({8'hA5, 24'h123456});
    sendBits(32'h0012_3456, 24);
    frameEnd("R3");

    // R2: serial clock toggles while frame strobe high
    curReq = "R2";
    for (int i = 0; i < 10; i++) sendBit(i[0]);
    waitClk(6);
    check("R2 idle edges", {31'd0, wrStrobe}, 32'd0);
    burst("R2", 8'h3C, 1, 0);

    // R6: burst of four
    burst("R6", 8'h10, 4, 0);

    // R7: wrap across 0xFF
    burst("R7", 8'hFE, 4, 0);

    // R8: partial word after two full ones
    burst("R8", 8'h40, 2, 13);
    burst("R8", 8'h41, 0, 23);
    burst("R8", 8'h77, 1, 0);

    // R9: partial address
    curReq = "R9";
    frameStart();
    sendBits(32'h55, 5);
    frameEnd("R9");
    burst("R9", 8'h09, 1, 0);

    // R10: final edge coincides with strobe release
    curReq = "R10";
    frameStart();
    sendBits(32'h0000_0022, 8);
    expQ.push_back({8'h22, 24'hABCDEF});
    sendBits(32'h00AB_CDEF, 24);
    sendBits(32'h0000_1234, 23);
    serDataIn = 1'b1; waitClk(HOLD);
    serClkIn = 1'b1; serLoadN = 1'b1;
    waitClk(HOLD);
    serClkIn = 1'b0;
    waitClk(8);
    check("R10 pending writes", expQ.size(), 0);
    expQ.delete();
    burst("R10", 8'h23, 1, 0);

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int nw = int'($urandom_range(1, 4));
      int tb = (($urandom & 3) == 0) ? int'($urandom_range(1, 23)) : 0;
      burst(nw > 1 ? "R6" : "R4", 8'($urandom), nw, tb);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule